// File: doc/BRIEF.md
# Programmable Auto-Refresh Request Timer

This block paces the auto-refresh traffic of a synchronous DRAM controller. A free-running up-counter, clocked by the oscillator clock, climbs from zero toward a terminal count held in a software-programmable register. Once it reaches that count, the block emits a one-clock refresh request to the command sequencer, clears the counter and starts the next interval. The interval is therefore one clock longer than the programmed value.

The block does not issue the DRAM commands itself. Software picks a terminal count small enough that the refresh command sequence still fits inside the device's refresh period. While the memory sits in self-refresh, the counter is held at zero, and it starts a fresh interval when self-refresh ends. A cold reset loads the largest terminal count. A warm reset restarts the counter and leaves the programmed count as it was.

Top module: `refresh_timer`

## Requirements
- R1: After cold reset (`rst_ni` low), the read port returns 0xFFF and `refresh_req_o` is low.
- R2: While self-refresh is low and the count is below the terminal value, the counter rises by one on each clock and no request is raised.
- R3: On the first clock edge at which the count equals the terminal value L, `refresh_req_o` goes high for exactly one clock. It stays low between requests, so requests repeat every L+1 clocks.
- R4: The clock edge that raises a request also clears the counter to zero, and counting then resumes from zero.
- R5: While `self_refresh_i` is high, the counter is held at zero and no request is raised. After release, the first request comes L+1 clocks later.
- R6: A warm reset (`warm_rst_ni` low) clears the counter and the request output but keeps the terminal value. After release, the next request comes L+1 clocks later.
- R7: A write (`cfg_we_i` high at a clock edge) loads bits 11:0 of `cfg_wdata_i` into the terminal register, which `cfg_rdata_o` returns from the next cycle. Without a write, the register holds its value.
- R8: If the count is above the terminal value, for example after the value has been lowered by a write, the next clock edge raises a request and clears the counter. The counter never wraps past 4095.
- R9: A terminal value of 0 raises a request on every clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Cold reset, asynchronous, active low |
| warm_rst_ni | input | 1 | Warm reset, asynchronous, active low; restarts the counter only |
| cfg_we_i | input | 1 | Write strobe for the terminal count |
| cfg_wdata_i | input | 12 | Terminal count write data |
| cfg_rdata_o | output | 12 | Terminal count read data |
| self_refresh_i | input | 1 | Memory is in self-refresh; holds the counter at zero |
| refresh_req_o | output | 1 | One-clock auto-refresh request |

## Verification
The assertions take `self_refresh_i`, `cfg_we_i` and the warm reset to be synchronous to `clk_i`. They also assume the terminal count changes only through the write strobe. The stimulus drives every input on the falling edge and samples outputs there too, so no change falls on a rising edge. It measures request intervals over a table of terminal counts, including 0 and 1. Directed cases then lower the count below a running counter, hold self-refresh for long stretches, and pulse the warm reset in the middle of an interval.

// File: rtl/refresh_timer_pkg.sv
package refresh_timer_pkg;
  localparam int unsigned CNT_W = 12;
  localparam logic [CNT_W-1:0] COLD_LIMIT = '1;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/rfsh_limit_reg.sv
module rfsh_limit_reg
  import refresh_timer_pkg::*;
#(
  parameter cnt_t RESET_VAL = COLD_LIMIT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  cnt_t wdata_i,
  output cnt_t limit_o
);
  cnt_t limit_q;

  // cold reset only; warm reset must not reach this flop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   limit_q <= RESET_VAL;
    else if (we_i) limit_q <= wdata_i;
  end

  assign limit_o = limit_q;

  AST_LIMIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(limit_q)); // R7
  AST_LIMIT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> limit_q == $past(wdata_i)); // R7
endmodule

// File: rtl/rfsh_counter.sv
module rfsh_counter
  import refresh_timer_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  cnt_t limit_i,
  output logic req_o
);
  cnt_t cnt_q;
  logic req_q;
  logic terminal;

  // >= rather than == so a lowered limit cannot let the count wrap
  assign terminal = (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else if (hold_i) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else if (terminal) begin
      cnt_q <= '0;
      req_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      req_q <= 1'b0;
    end
  end

  assign req_o = req_q;

  AST_COUNT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && cnt_q < limit_i) |=> (cnt_q == $past(cnt_q) + 1'b1) && !req_q); // R2
  AST_REQ_AT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && cnt_q == limit_i) |=> req_q); // R3
  AST_REQ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> cnt_q == '0); // R4
  AST_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == '0) && !req_q); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && cnt_q > limit_i) |=> (cnt_q == '0) && req_q); // R8
endmodule

// File: rtl/refresh_timer.sv
module refresh_timer
  import refresh_timer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             warm_rst_ni,
  input  logic             cfg_we_i,
  input  logic [CNT_W-1:0] cfg_wdata_i,
  output logic [CNT_W-1:0] cfg_rdata_o,
  input  logic             self_refresh_i,
  output logic             refresh_req_o
);
  cnt_t limit;
  logic cnt_rst_n;

  // counter restarts on either reset; limit register sees cold reset only
  assign cnt_rst_n = rst_ni & warm_rst_ni;

  rfsh_limit_reg #(.RESET_VAL(COLD_LIMIT)) u_limit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .limit_o (limit)
  );

  rfsh_counter u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (cnt_rst_n),
    .hold_i  (self_refresh_i),
    .limit_i (limit),
    .req_o   (refresh_req_o)
  );

  assign cfg_rdata_o = limit;

  AST_ZERO_LIMIT_EVERY_CLK: assert property (@(posedge clk_i) disable iff (!cnt_rst_n)
    (!self_refresh_i && limit == '0) |=> refresh_req_o); // R9
  AST_WARM_KEEPS_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!warm_rst_ni && !cfg_we_i) |=> $stable(cfg_rdata_o)); // R6
endmodule

// File: tb/refresh_timer_bench.sv
module refresh_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 6;
  localparam logic [11:0] VEC_LIMIT [N_VEC] = '{12'd0, 12'd1, 12'd2, 12'd5, 12'd17, 12'd100};
  localparam int VEC_PERIOD [N_VEC] = '{1, 2, 3, 6, 18, 101};

  logic clk = 1'b0;
  logic rst_n = 1'b0, warm_rst_n = 1'b1, we = 1'b0, sr = 1'b0;
  logic [11:0] wdata = '0;
  logic [11:0] rdata;
  logic req;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_timer u_refresh_timer (
    .clk_i(clk), .rst_ni(rst_n), .warm_rst_ni(warm_rst_n),
    .cfg_we_i(we), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .self_refresh_i(sr), .refresh_req_o(req)
  );

  task automatic check(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // called at a negedge; counts clocks until req is seen high
  task automatic wait_req(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!req && n < 5000);
  endtask

  task automatic write_limit(input logic [11:0] v);
    we = 1'b1; wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic restart_with_sr();
    sr = 1'b1;
    @(negedge clk);
    sr = 1'b0;
  endtask

  initial begin
    int n;
    int hits;
    repeat (3) @(negedge clk);
    check("R1 cold limit", int'(rdata), 4095);
    check("R1 req low", int'(req), 0);
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < N_VEC; i++) begin
      sr = 1'b1;
      write_limit(VEC_LIMIT[i]);
      check("R7 readback", int'(rdata), int'(VEC_LIMIT[i]));
      restart_with_sr();
      wait_req(n);
      check("R5 first req after release", n, VEC_PERIOD[i]);
      if (VEC_PERIOD[i] > 1) begin
        @(negedge clk);
        check("R3 pulse one clock", int'(req), 0);
        wait_req(n);
        check("R2 R4 period", n + 1, VEC_PERIOD[i]);
      end else begin
        wait_req(n);
        check("R9 back-to-back", n, 1);
      end
    end

    // R9 zero limit: every clock
    write_limit(12'd0);
    hits = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      hits += int'(req);
    end
    check("R9 requests in 8 clocks", hits, 8);

    // R5 long self-refresh hold
    write_limit(12'd3);
    sr = 1'b1;
    hits = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      hits += int'(req);
    end
    check("R5 no req while held", hits, 0);
    sr = 1'b0;
    wait_req(n);
    check("R5 release interval", n, 4);

    // R6 warm reset mid-interval
    write_limit(12'd10);
    restart_with_sr();
    repeat (5) @(negedge clk);
    warm_rst_n = 1'b0;
    @(negedge clk);
    check("R6 req low in warm reset", int'(req), 0);
    check("R6 limit kept", int'(rdata), 10);
    warm_rst_n = 1'b1;
    wait_req(n);
    check("R6 interval after warm reset", n, 11);

    // R8 lower limit below running count
    write_limit(12'd200);
    restart_with_sr();
    repeat (50) @(negedge clk);
    check("R2 no req below limit", int'(req), 0);
    we = 1'b1; wdata = 12'd5;
    wait_req(n);
    we = 1'b0;
    check("R8 clear after lowering", n, 2);
    wait_req(n);
    check("R8 next interval", n, 6);

    // R7 no write keeps value
    repeat (20) @(negedge clk);
    check("R7 hold without write", int'(rdata), 5);

    // R1 cold reset restores 0xFFF
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 cold reload", int'(rdata), 4095);
    rst_n = 1'b1;
    wait_req(n);
    check("R3 max interval", n, 4096);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule